// File: doc/BRIEF.md
# Saturating Accumulator ALU with Carry

This block is the arithmetic core around a 32-bit accumulator. Each clock it takes one opcode and updates the accumulator, a 32-bit buffer register, a carry bit and a sticky overflow flag. The accumulator is always the first operand. The second operand is one of three sources:

- a 16-bit data word passed through a left scaling shifter,
- the buffer register,
- a product value supplied from outside.

Additions and subtractions, with or without the stored carry, run through one shared 33-bit adder. Signed overflow can be clamped to the most positive or most negative value. Boolean operations combine the accumulator with the shifted word. Signed minimum and maximum operations compare the accumulator with the buffer, write the winner into both registers and report the outcome on carry.

A sequencer drives the block with one opcode per cycle. Results show on the outputs after the clock edge that consumes the opcode. The shift count is taken from an immediate field or from the low four bits of a temporary-register input. Two mode inputs select sign extension in the shifter and saturation on overflow.

Top module: `acc_alu`

## Requirements
- R1: After reset, the accumulator and buffer are 0, carry is 1 and overflow is 0.
- R2: The scaling shifter moves the data word left by 0 to 16 places and fills the low bits with zeros.
  - The high bits are copies of data bit 15 when sxm_i=1 and zeros when sxm_i=0.
  - The count is shift_imm_i when shift_sel_i=0; immediate values above 16 act as 16.
  - The count is treg_i[3:0] when shift_sel_i=1.
  - LOAD (code 1) writes the shifted word into the accumulator.
- R3: These operations write the accumulator and set carry to the adder's carry out:
  - ADD (2): accumulator plus shifted word.
  - SUB (3): accumulator minus shifted word.
  - ADDB (6): accumulator plus buffer.
  - SUBBUF (7): accumulator minus buffer.
  - ADDP (10): accumulator plus product.
  - A subtraction computes a + ~b + 1, so carry is 0 on a borrow and 1 otherwise.
- R4: These operations use the stored carry and update it like R3:
  - ADDC (4): accumulator plus shifted word plus carry.
  - SUBB (5): accumulator plus the inverted shifted word plus carry.
  - ADCB (8): accumulator plus buffer plus carry.
  - SBBB (9): accumulator plus the inverted buffer plus carry.
- R5: When the effective shift count is 16, ADD only sets carry (on a carry out) and SUB only clears carry (on a borrow). Otherwise carry keeps its value.
- R6: When ovm_i=1 and an arithmetic result overflows in the signed sense, the accumulator becomes 0x7FFFFFFF on positive overflow and 0x80000000 on negative overflow, and the overflow flag is set.
- R7: When ovm_i=0, an overflowing result is written wrapped and the flag is still set. The flag stays set until CLRV (19) clears it.
- R8: LOAD and the Boolean operations AND (11), OR (12) and XOR (13) combine with the shifted word and never change carry or the overflow flag.
- R9: MIN (14) keeps the accumulator if it is signed-less-than the buffer, and otherwise keeps the buffer. MAX (15) does the same for signed-greater-than. The kept value goes to both registers, and carry is 1 if the condition held and 0 otherwise.
- R10: Four operations affect only the named state:
  - SAVEB (16) copies the accumulator into the buffer.
  - SETC (17) sets carry.
  - CLRC (18) clears carry.
  - NOP (0) and unused codes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 5 | Opcode |
| data_i | input | 16 | Data word into the scaling shifter |
| shift_imm_i | input | 5 | Immediate shift count |
| shift_sel_i | input | 1 | 1 selects treg_i[3:0] as shift count |
| treg_i | input | 16 | Temporary register value |
| prod_i | input | 32 | Product operand |
| sxm_i | input | 1 | Sign-extension mode for the shifter |
| ovm_i | input | 1 | Saturation mode |
| acc_o | output | 32 | Accumulator |
| buf_o | output | 32 | Buffer register |
| carry_o | output | 1 | Carry bit |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Every piece of state is a port, so a wrong update appears on acc_o, buf_o, carry_o or ovf_o one cycle after the opcode that caused it. A carry or overflow error that does not show in the accumulator becomes visible through a later carry-consuming operation or through the flag, within a few cycles. The stimulus chains operations so that each result feeds the next: the high-word carry case, saturation in both directions, and signed versus unsigned comparison each change a value that is checked directly.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_NOP    = 5'd0,
    OP_LOAD   = 5'd1,
    OP_ADD    = 5'd2,
    OP_SUB    = 5'd3,
    OP_ADDC   = 5'd4,
    OP_SUBB   = 5'd5,
    OP_ADDB   = 5'd6,
    OP_SUBBUF = 5'd7,
    OP_ADCB   = 5'd8,
    OP_SBBB   = 5'd9,
    OP_ADDP   = 5'd10,
    OP_AND    = 5'd11,
    OP_OR     = 5'd12,
    OP_XOR    = 5'd13,
    OP_MIN    = 5'd14,
    OP_MAX    = 5'd15,
    OP_SAVEB  = 5'd16,
    OP_SETC   = 5'd17,
    OP_CLRC   = 5'd18,
    OP_CLRV   = 5'd19
  } op_e;

  typedef enum logic [1:0] {
    SRC_SHIFT = 2'd0,
    SRC_BUF   = 2'd1,
    SRC_PROD  = 2'd2
  } src_e;
endpackage

// File: rtl/acc_scale_shifter.sv
module acc_scale_shifter #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              sxm_i,
  output logic [ACC_W-1:0]  shifted_o
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic [ACC_W-1:0] ext;

  always_comb begin
    ext       = {{EXT_W{sxm_i & data_i[DATA_W-1]}}, data_i};
    shifted_o = ext << cnt_i;
  end
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o,
  output logic         ovf_pos_o
);
  logic [W-1:0] bb;
  logic [W:0]   full;

  always_comb begin
    bb     = inv_b_i ? ~b_i : b_i;
    // one carry chain yields both carry and overflow
    full   = {1'b0, a_i} + {1'b0, bb} + {{W{1'b0}}, cin_i};
    sum_o  = full[W-1:0];
    cout_o = full[W];
    ovf_o  = (a_i[W-1] == bb[W-1]) && (full[W-1] != a_i[W-1]);
    ovf_pos_o = ~a_i[W-1];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [4:0]                op_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [$clog2(DATA_W+1)-1:0] shift_imm_i,
  input  logic                      shift_sel_i,
  input  logic [DATA_W-1:0]         treg_i,
  input  logic [ACC_W-1:0]          prod_i,
  input  logic                      sxm_i,
  input  logic                      ovm_i,
  output logic [ACC_W-1:0]          acc_o,
  output logic [ACC_W-1:0]          buf_o,
  output logic                      carry_o,
  output logic                      ovf_o
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int TCNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MAX_SH = CNT_W'(DATA_W);
  localparam logic [ACC_W-1:0] SAT_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  op_e op;
  assign op = op_e'(op_i);

  logic [ACC_W-1:0] acc_q, buf_q;
  logic             carry_q, ovf_q;

  // shift count select and clamp
  logic [CNT_W-1:0] cnt_eff;
  logic             cnt_hi;
  always_comb begin
    if (shift_sel_i)            cnt_eff = {{(CNT_W-TCNT_W){1'b0}}, treg_i[TCNT_W-1:0]};
    else if (shift_imm_i > MAX_SH) cnt_eff = MAX_SH;
    else                        cnt_eff = shift_imm_i;
    cnt_hi = (cnt_eff == MAX_SH);
  end

  logic [ACC_W-1:0] shifted;
  acc_scale_shifter #(.DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_shift (
    .data_i   (data_i),
    .cnt_i    (cnt_eff),
    .sxm_i    (sxm_i),
    .shifted_o(shifted)
  );

  // operand routing and adder control
  src_e src;
  logic is_arith, inv_b, cin, use_c;
  always_comb begin
    src      = SRC_SHIFT;
    is_arith = 1'b1;
    inv_b    = 1'b0;
    use_c    = 1'b0;
    unique case (op)
      OP_ADD:    ;
      OP_SUB:    inv_b = 1'b1;
      OP_ADDC:   use_c = 1'b1;
      OP_SUBB:   begin inv_b = 1'b1; use_c = 1'b1; end
      OP_ADDB:   src = SRC_BUF;
      OP_SUBBUF: begin src = SRC_BUF; inv_b = 1'b1; end
      OP_ADCB:   begin src = SRC_BUF; use_c = 1'b1; end
      OP_SBBB:   begin src = SRC_BUF; inv_b = 1'b1; use_c = 1'b1; end
      OP_ADDP:   src = SRC_PROD;
      default:   is_arith = 1'b0;
    endcase
    cin = use_c ? carry_q : inv_b;
  end

  logic [ACC_W-1:0] opnd_b;
  always_comb begin
    unique case (src)
      SRC_BUF:  opnd_b = buf_q;
      SRC_PROD: opnd_b = prod_i;
      default:  opnd_b = shifted;
    endcase
  end

  logic [ACC_W-1:0] sum;
  logic             cout, add_ovf, ovf_pos;
  acc_adder #(.W(ACC_W)) u_add (
    .a_i      (acc_q),
    .b_i      (opnd_b),
    .inv_b_i  (inv_b),
    .cin_i    (cin),
    .sum_o    (sum),
    .cout_o   (cout),
    .ovf_o    (add_ovf),
    .ovf_pos_o(ovf_pos)
  );

  logic acc_lt_buf, acc_gt_buf;
  assign acc_lt_buf = $signed(acc_q) < $signed(buf_q);
  assign acc_gt_buf = $signed(acc_q) > $signed(buf_q);

  // next-state
  logic [ACC_W-1:0] acc_d, buf_d;
  logic             carry_d, ovf_d;
  always_comb begin
    acc_d   = acc_q;
    buf_d   = buf_q;
    carry_d = carry_q;
    ovf_d   = ovf_q;
    if (is_arith) begin
      if (add_ovf) begin
        ovf_d = 1'b1;
        acc_d = ovm_i ? (ovf_pos ? SAT_POS : SAT_NEG) : sum;
      end else begin
        acc_d = sum;
      end
      if (cnt_hi && op == OP_ADD)      carry_d = carry_q | cout;
      else if (cnt_hi && op == OP_SUB) carry_d = carry_q & cout;
      else                             carry_d = cout;
    end else begin
      unique case (op)
        OP_LOAD:  acc_d = shifted;
        OP_AND:   acc_d = acc_q & shifted;
        OP_OR:    acc_d = acc_q | shifted;
        OP_XOR:   acc_d = acc_q ^ shifted;
        OP_MIN: begin
          acc_d   = acc_lt_buf ? acc_q : buf_q;
          buf_d   = acc_d;
          carry_d = acc_lt_buf;
        end
        OP_MAX: begin
          acc_d   = acc_gt_buf ? acc_q : buf_q;
          buf_d   = acc_d;
          carry_d = acc_gt_buf;
        end
        OP_SAVEB: buf_d   = acc_q;
        OP_SETC:  carry_d = 1'b1;
        OP_CLRC:  carry_d = 1'b0;
        OP_CLRV:  ovf_d   = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      buf_q   <= '0;
      carry_q <= 1'b1;
      ovf_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      buf_q   <= buf_d;
      carry_q <= carry_d;
      ovf_q   <= ovf_d;
    end
  end

  assign acc_o   = acc_q;
  assign buf_o   = buf_q;
  assign carry_o = carry_q;
  assign ovf_o   = ovf_q;

  AST_SAT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_arith && ovm_i && add_ovf) |=> (acc_q == SAT_POS || acc_q == SAT_NEG)); // R6
  AST_OVF_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_arith && add_ovf) |=> ovf_q); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && op != OP_CLRV) |=> ovf_q); // R7
  AST_CARRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op inside {OP_LOAD, OP_AND, OP_OR, OP_XOR}) |=> $stable(carry_q)); // R8
  AST_MINMAX_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op inside {OP_MIN, OP_MAX}) |=> (acc_q == buf_q)); // R9
  AST_HI_ADD_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ADD && cnt_hi && carry_q) |=> carry_q); // R5
  AST_HI_SUB_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SUB && cnt_hi && !carry_q) |=> !carry_q); // R5
  AST_SETC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SETC) |=> carry_q); // R10
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] data = '0;
  logic [4:0]  imm = '0;
  logic        sel = 1'b0;
  logic [15:0] treg = 16'h0005;
  logic [31:0] prod = 32'h0002_2220;
  logic        sxm = 1'b0;
  logic        ovm = 1'b0;
  logic [31:0] acc, bufr;
  logic        carry, ovf;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  acc_alu u_acc_alu (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .data_i(data),
    .shift_imm_i(imm), .shift_sel_i(sel), .treg_i(treg), .prod_i(prod),
    .sxm_i(sxm), .ovm_i(ovm), .acc_o(acc), .buf_o(bufr),
    .carry_o(carry), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  op;
    logic [15:0] data;
    logic [4:0]  imm;
    logic        sel;
    logic        sxm;
    logic        ovm;
    logic [31:0] e_acc;
    logic [31:0] e_buf;
    logic        e_c;
    logic        e_v;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t TBL [NV] = '{
    '{4'd2,  5'd1,  16'h8001, 5'd4,  1'b0, 1'b1, 1'b0, 32'hFFF8_0010, 32'h0000_0000, 1'b1, 1'b0}, // R2 sign ext
    '{4'd2,  5'd1,  16'h8001, 5'd4,  1'b0, 1'b0, 1'b0, 32'h0008_0010, 32'h0000_0000, 1'b1, 1'b0}, // R2 zero ext
    '{4'd3,  5'd2,  16'h0001, 5'd0,  1'b1, 1'b0, 1'b0, 32'h0008_0030, 32'h0000_0000, 1'b0, 1'b0}, // R3 treg count
    '{4'd3,  5'd3,  16'h0031, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0007_FFFF, 32'h0000_0000, 1'b1, 1'b0}, // R3 no borrow
    '{4'd10, 5'd18, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0007_FFFF, 32'h0000_0000, 1'b0, 1'b0}, // R10 CLRC
    '{4'd5,  5'd3,  16'h0001, 5'd20, 1'b0, 1'b0, 1'b0, 32'h0006_FFFF, 32'h0000_0000, 1'b0, 1'b0}, // R5 clamp, carry kept
    '{4'd10, 5'd16, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0006_FFFF, 32'h0006_FFFF, 1'b0, 1'b0}, // R10 SAVEB
    '{4'd2,  5'd1,  16'hFFFF, 5'd16, 1'b0, 1'b0, 1'b0, 32'hFFFF_0000, 32'h0006_FFFF, 1'b0, 1'b0}, // R2
    '{4'd5,  5'd2,  16'h0001, 5'd16, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0006_FFFF, 1'b1, 1'b0}, // R5 sets carry
    '{4'd4,  5'd4,  16'h0002, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0000_0003, 32'h0006_FFFF, 1'b0, 1'b0}, // R4 ADDC
    '{4'd4,  5'd5,  16'h0001, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0000_0001, 32'h0006_FFFF, 1'b1, 1'b0}, // R4 SUBB
    '{4'd4,  5'd8,  16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0007_0001, 32'h0006_FFFF, 1'b0, 1'b0}, // R4 ADCB
    '{4'd4,  5'd9,  16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0000_0001, 32'h0006_FFFF, 1'b1, 1'b0}, // R4 SBBB
    '{4'd3,  5'd10, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0002_2221, 32'h0006_FFFF, 1'b0, 1'b0}, // R3 ADDP
    '{4'd2,  5'd1,  16'h7FFF, 5'd16, 1'b0, 1'b1, 1'b0, 32'h7FFF_0000, 32'h0006_FFFF, 1'b0, 1'b0}, // R2
    '{4'd6,  5'd2,  16'h7FFF, 5'd16, 1'b0, 1'b1, 1'b1, 32'h7FFF_FFFF, 32'h0006_FFFF, 1'b0, 1'b1}, // R6 positive sat
    '{4'd7,  5'd19, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0006_FFFF, 1'b0, 1'b0}, // R7 CLRV
    '{4'd2,  5'd1,  16'h8000, 5'd16, 1'b0, 1'b1, 1'b0, 32'h8000_0000, 32'h0006_FFFF, 1'b0, 1'b0}, // R2
    '{4'd6,  5'd3,  16'h0001, 5'd0,  1'b0, 1'b0, 1'b1, 32'h8000_0000, 32'h0006_FFFF, 1'b1, 1'b1}, // R6 negative sat
    '{4'd7,  5'd19, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h8000_0000, 32'h0006_FFFF, 1'b1, 1'b0}, // R7
    '{4'd7,  5'd3,  16'h0001, 5'd0,  1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0006_FFFF, 1'b1, 1'b1}, // R7 wrap
    '{4'd8,  5'd13, 16'hFFFF, 5'd0,  1'b0, 1'b0, 1'b0, 32'h7FFF_0000, 32'h0006_FFFF, 1'b1, 1'b1}, // R8 XOR
    '{4'd8,  5'd12, 16'h1234, 5'd0,  1'b0, 1'b0, 1'b0, 32'h7FFF_1234, 32'h0006_FFFF, 1'b1, 1'b1}, // R8 OR
    '{4'd9,  5'd14, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0006_FFFF, 32'h0006_FFFF, 1'b0, 1'b1}, // R9 MIN false
    '{4'd8,  5'd1,  16'h0005, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0000_0005, 32'h0006_FFFF, 1'b0, 1'b1}, // R8 LOAD
    '{4'd9,  5'd14, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0005, 1'b1, 1'b1}, // R9 MIN true
    '{4'd8,  5'd1,  16'h8000, 5'd0,  1'b0, 1'b1, 1'b0, 32'hFFFF_8000, 32'h0000_0005, 1'b1, 1'b1}, // R8
    '{4'd9,  5'd15, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1}, // R9 MAX signed false
    '{4'd8,  5'd1,  16'h0007, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_0005, 1'b0, 1'b1}, // R8
    '{4'd9,  5'd15, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'h0000_0007, 32'h0000_0007, 1'b1, 1'b1}, // R9 MAX true
    '{4'd8,  5'd1,  16'h8000, 5'd0,  1'b0, 1'b1, 1'b0, 32'hFFFF_8000, 32'h0000_0007, 1'b1, 1'b1}, // R8
    '{4'd9,  5'd14, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'hFFFF_8000, 32'hFFFF_8000, 1'b1, 1'b1}, // R9 signed MIN
    '{4'd10, 5'd18, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'hFFFF_8000, 32'hFFFF_8000, 1'b0, 1'b1}, // R10 CLRC
    '{4'd10, 5'd17, 16'h0000, 5'd0,  1'b0, 1'b0, 1'b0, 32'hFFFF_8000, 32'hFFFF_8000, 1'b1, 1'b1}, // R10 SETC
    '{4'd10, 5'd0,  16'hFFFF, 5'd3,  1'b0, 1'b1, 1'b1, 32'hFFFF_8000, 32'hFFFF_8000, 1'b1, 1'b1}  // R10 NOP
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [31:0] ea,
                           input logic [31:0] eb, input logic ec, input logic ev);
    check(req, "acc", acc, ea);
    check(req, "buf", bufr, eb);
    check(req, "carry", {31'd0, carry}, {31'd0, ec});
    check(req, "ovf", {31'd0, ovf}, {31'd0, ev});
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    check_all("R1", 32'h0, 32'h0, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", 32'h0, 32'h0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      op   = TBL[i].op;
      data = TBL[i].data;
      imm  = TBL[i].imm;
      sel  = TBL[i].sel;
      sxm  = TBL[i].sxm;
      ovm  = TBL[i].ovm;
      @(negedge clk);
      check_all($sformatf("R%0d step %0d", TBL[i].req, i), TBL[i].e_acc,
                TBL[i].e_buf, TBL[i].e_c, TBL[i].e_v);
    end

    // R2: only treg low bits select the count
    treg = 16'hFFF3; op = 5'd1; data = 16'h0001; sel = 1'b1; sxm = 1'b0; ovm = 1'b0;
    @(negedge clk);
    check("R2", "treg count", acc, 32'h0000_0008);

    // R10: unused code leaves state alone
    op = 5'd31; data = 16'h1234; sel = 1'b0;
    @(negedge clk);
    check_all("R10", 32'h0000_0008, 32'hFFFF_8000, 1'b1, 1'b1);

    // R1: reset mid-run
    op = 5'd0;
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1", 32'h0, 32'h0, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule